// File: doc/BRIEF.md
# Reference Monitor with Switchover and Holdover

This block sits in the system-clock domain of a clock-synthesis subsystem. It watches two incoming reference clocks, judges each one healthy or quiet, and picks the one a downstream phase detector should lock to. The choice is made either automatically or by host command. When no usable reference remains, the block enters holdover. In holdover it hands the downstream numerically controlled oscillator a tuning word taken from a clamped running average of the live word. If no such history exists yet, it hands over a fixed free-run word.

The live tuning word comes from the phase detector and loop filter, which are outside this block. The history average is updated only while the block is locked to a healthy reference. The reference passed on (`ref_out`) never carries a shortened or stretched high pulse when the source changes. A change of source waits until the old output is low and the new reference is low before the select moves. A one-cycle interrupt marks every change of the reported mode.

State machine states:
- `ST_FREE`: free-run, no history.
- `ST_HOLD`: holdover from history.
- `ST_ACT_A` / `ST_ACT_B`: locked to a reference.
- `ST_SW_A` / `ST_SW_B`: waiting for a safe low point before taking the named reference.

Transitions:
- FREE/HOLD to SW_x: a wanted reference becomes valid.
- SW_x to ACT_x: the output and the new reference are both low.
- ACT_x to SW_y: the active reference failed or the host asks for the other one, and the other is valid.
- ACT_x or SW_x to HOLD or FREE: the wanted reference is unusable or the host forces holdover. The target is HOLD if history exists, otherwise FREE.

Top module: `ref_switch_holdover`

## Requirements
- R1: A reference is reported valid (`ref_a_ok`/`ref_b_ok`) only after `good_need` rising edges, each arriving before `win_len` system clocks have passed without an edge. It is reported failed once `win_len` clocks pass with no rising edge.
- R2: In automatic mode (`man_en`=0, `man_hold`=0), leaving FREE/HOLD picks A when A is valid, otherwise B. Selection is non-revertive: a reference that recovers does not displace a valid active one.
- R3: In automatic mode, when the active reference fails and the other is valid, the block moves to the other one. `sel_b` is 1 exactly when B is the source.
- R4: With no usable reference, the mode becomes HOLD if tuning history exists, otherwise FREE. `mode` encodes FREE=0, ACT_A=1, ACT_B=2, HOLD=3.
- R5: The block leaves HOLD as soon as a wanted reference becomes valid.
- R6: `man_hold`=1 forces HOLD/FREE. With `man_en`=1, `man_src` (0 = A, 1 = B) names the reference; if that one is not valid, the block goes to HOLD/FREE instead of using the other.
- R7: `tw_out` equals `live_tw` in ACT_A/ACT_B, the clamped history in HOLD, and `FREE_TW` in FREE.
- R8: History is updated only on cycles where the mode is ACT_x, reference x is valid and `lock_ok`=1. The first such update loads `live_tw`. Each later update moves the average toward `live_tw` by `|live_tw - avg| >> AVG_SHIFT`.
- R9: The history word is clamped to [`CLAMP_LO`, `CLAMP_HI`] before use.
- R10: `sel_b` changes only while `ref_out` is low. Every high pulse on `ref_out` has the full length of a high phase of its source.
- R11: `irq` is high for exactly the cycles in which `mode` has just changed.
- R12: After reset: mode FREE, `sel_b`=0, `ref_out`=0, `irq`=0, both references not valid, `tw_out`=`FREE_TW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Reference A (asynchronous) |
| ref_b | input | 1 | Reference B (asynchronous) |
| win_len | input | CNT_W | Quiet window in system clocks |
| good_need | input | GOOD_W | Consecutive good edges needed for validity |
| man_hold | input | 1 | Host forces holdover |
| man_en | input | 1 | Host selects reference manually |
| man_src | input | 1 | Manual source, 0 = A, 1 = B |
| lock_ok | input | 1 | Live tuning word is locked and usable |
| live_tw | input | TW_W | Live tuning word from the loop filter |
| ref_out | output | 1 | Selected reference, free of runt pulses |
| sel_b | output | 1 | Active select, 1 = B |
| mode | output | 2 | FREE=0, ACT_A=1, ACT_B=2, HOLD=3 |
| ref_a_ok | output | 1 | Reference A valid |
| ref_b_ok | output | 1 | Reference B valid |
| irq | output | 1 | One-cycle pulse on mode change |
| tw_out | output | TW_W | Tuning word for the downstream NCO |

## Verification
The bench drives the two references with unrelated half-periods. It measures every high pulse on `ref_out` across automatic switchovers and random manual source changes. A select that moved mid-pulse would show up as a pulse shorter or longer than either half-period. The history average is checked against a bench model after a random number of qualified updates, with values above and below the clamp bounds. A design that kept averaging when unlocked, skipped the initial load or forgot the clamp would hand holdover a wrong word. Further directed cases cover:
- a manually named reference that is invalid, where a design that fell back to the other reference would miss holdover;
- a recovering reference A while B is active, where a revertive design would switch back;
- holdover with no history, where the free-run word must appear.

// File: rtl/ref_guard_pkg.sv
package ref_guard_pkg;
    typedef enum logic [2:0] {
        ST_FREE,
        ST_HOLD,
        ST_ACT_A,
        ST_ACT_B,
        ST_SW_A,
        ST_SW_B
    } fsm_st_t;

    typedef enum logic [1:0] {
        MD_FREE  = 2'd0,
        MD_ACT_A = 2'd1,
        MD_ACT_B = 2'd2,
        MD_HOLD  = 2'd3
    } mode_t;
endpackage

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
    parameter int CNT_W  = 16,
    parameter int GOOD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [GOOD_W-1:0] good_need,
    output logic              ref_lvl,
    output logic              ref_ok
);
    logic [2:0]        sync_q;
    logic              rise;
    logic              timeout;
    logic [CNT_W-1:0]  gap_q;
    logic [GOOD_W-1:0] goods_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_in};
    end

    assign ref_lvl = sync_q[1];
    assign rise    = sync_q[1] & ~sync_q[2];
    assign timeout = ({1'b0, gap_q} + 1'b1) >= {1'b0, win_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            goods_q <= '0;
            ref_ok  <= 1'b0;
        end else if (rise) begin
            gap_q <= '0;
            if (!ref_ok) begin
                if (({1'b0, goods_q} + 1'b1) >= {1'b0, good_need}) begin
                    ref_ok  <= 1'b1;
                    goods_q <= '0;
                end else begin
                    goods_q <= goods_q + 1'b1;
                end
            end
        end else if (timeout) begin
            gap_q   <= '0;
            goods_q <= '0;
            ref_ok  <= 1'b0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_ok_rises_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok) |-> $past(rise));
    assert_ok_falls_when_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_ok) |-> !$past(rise));
endmodule

// File: rtl/tw_history.sv
module tw_history #(
    parameter int              TW_W      = 24,
    parameter int              AVG_SHIFT = 3,
    parameter logic [TW_W-1:0] CLAMP_LO  = '0,
    parameter logic [TW_W-1:0] CLAMP_HI  = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_en,
    input  logic [TW_W-1:0] live_tw,
    output logic            have_hist,
    output logic [TW_W-1:0] hist_tw
);
    logic [TW_W-1:0] avg_q;
    logic [TW_W-1:0] avg_d;
    logic [TW_W-1:0] up_step;
    logic [TW_W-1:0] dn_step;

    always_comb begin
        up_step = (live_tw - avg_q) >> AVG_SHIFT;
        dn_step = (avg_q - live_tw) >> AVG_SHIFT;
        if (!have_hist)            avg_d = live_tw;
        else if (live_tw >= avg_q) avg_d = avg_q + up_step;
        else                       avg_d = avg_q - dn_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_q     <= '0;
            have_hist <= 1'b0;
        end else if (upd_en) begin
            avg_q     <= avg_d;
            have_hist <= 1'b1;
        end
    end

    always_comb begin
        if (avg_q > CLAMP_HI)      hist_tw = CLAMP_HI;
        else if (avg_q < CLAMP_LO) hist_tw = CLAMP_LO;
        else                       hist_tw = avg_q;
    end

    assert_hist_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(avg_q));
    assert_first_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !have_hist) |=> (avg_q == $past(live_tw)));
endmodule

// File: rtl/ref_switch_fsm.sv
module ref_switch_fsm
    import ref_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_ok,
    input  logic       b_ok,
    input  logic       a_lvl,
    input  logic       b_lvl,
    input  logic       have_hist,
    input  logic       man_hold,
    input  logic       man_en,
    input  logic       man_src,
    output mode_t      mode,
    output logic       sel_b,
    output logic       ref_out,
    output logic       irq
);
    fsm_st_t state_q, state_d;
    fsm_st_t noref;
    mode_t   mode_d;
    logic    keep_mode;

    assign noref = have_hist ? ST_HOLD : ST_FREE;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACT_A: begin
                if (man_hold)           state_d = noref;
                else if (man_en) begin
                    if (man_src)        state_d = b_ok ? ST_SW_B : noref;
                    else if (!a_ok)     state_d = noref;
                end else if (!a_ok)     state_d = b_ok ? ST_SW_B : noref;
            end
            ST_ACT_B: begin
                if (man_hold)           state_d = noref;
                else if (man_en) begin
                    if (!man_src)       state_d = a_ok ? ST_SW_A : noref;
                    else if (!b_ok)     state_d = noref;
                end else if (!b_ok)     state_d = a_ok ? ST_SW_A : noref;
            end
            ST_FREE, ST_HOLD: begin
                if (!man_hold) begin
                    if (man_en) begin
                        if (man_src && b_ok)        state_d = ST_SW_B;
                        else if (!man_src && a_ok)  state_d = ST_SW_A;
                    end else if (a_ok)              state_d = ST_SW_A;
                    else if (b_ok)                  state_d = ST_SW_B;
                end
            end
            ST_SW_A: begin
                if (man_hold || !a_ok || (man_en && man_src)) state_d = noref;
                else if (!ref_out && !a_lvl)                  state_d = ST_ACT_A;
            end
            ST_SW_B: begin
                if (man_hold || !b_ok || (man_en && !man_src)) state_d = noref;
                else if (!ref_out && !b_lvl)                   state_d = ST_ACT_B;
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        keep_mode = 1'b0;
        mode_d    = mode;
        unique case (state_q)
            ST_FREE:  mode_d = MD_FREE;
            ST_HOLD:  mode_d = MD_HOLD;
            ST_ACT_A: mode_d = MD_ACT_A;
            ST_ACT_B: mode_d = MD_ACT_B;
            default:  keep_mode = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= MD_FREE;
            irq     <= 1'b0;
            sel_b   <= 1'b0;
            ref_out <= 1'b0;
        end else begin
            irq <= !keep_mode && (mode_d != mode);
            if (!keep_mode) mode <= mode_d;
            unique case (state_q)
                ST_ACT_A: begin
                    sel_b   <= 1'b0;
                    ref_out <= a_lvl;
                end
                ST_ACT_B: begin
                    sel_b   <= 1'b1;
                    ref_out <= b_lvl;
                end
                default: ref_out <= ref_out & (sel_b ? b_lvl : a_lvl);
            endcase
        end
    end

    assert_sel_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != $past(sel_b)) |-> !$past(ref_out));
    assert_irq_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> irq);
    assert_free_means_no_hist_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> have_hist);
    assert_rise_only_in_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_out) |-> ($past(state_q) == ST_ACT_A || $past(state_q) == ST_ACT_B));
endmodule

// File: rtl/ref_switch_holdover.sv
module ref_switch_holdover
    import ref_guard_pkg::*;
#(
    parameter int              TW_W      = 24,
    parameter int              CNT_W     = 16,
    parameter int              GOOD_W    = 4,
    parameter int              AVG_SHIFT = 3,
    parameter logic [TW_W-1:0] FREE_TW   = 24'h800000,
    parameter logic [TW_W-1:0] CLAMP_LO  = 24'h100000,
    parameter logic [TW_W-1:0] CLAMP_HI  = 24'hF00000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_a,
    input  logic              ref_b,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [GOOD_W-1:0] good_need,
    input  logic              man_hold,
    input  logic              man_en,
    input  logic              man_src,
    input  logic              lock_ok,
    input  logic [TW_W-1:0]   live_tw,
    output logic              ref_out,
    output logic              sel_b,
    output logic [1:0]        mode,
    output logic              ref_a_ok,
    output logic              ref_b_ok,
    output logic              irq,
    output logic [TW_W-1:0]   tw_out
);
    localparam int NREF = 2;

    logic [NREF-1:0] ref_raw;
    logic [NREF-1:0] lvl;
    logic [NREF-1:0] ok;
    logic            have_hist;
    logic            upd_en;
    logic [TW_W-1:0] hist_tw;
    mode_t           mode_e;

    assign ref_raw = {ref_b, ref_a};

    for (genvar g = 0; g < NREF; g++) begin : g_mon
        ref_activity_mon #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_in   (ref_raw[g]),
            .win_len  (win_len),
            .good_need(good_need),
            .ref_lvl  (lvl[g]),
            .ref_ok   (ok[g])
        );
    end

    assign upd_en = lock_ok && ((mode_e == MD_ACT_A && ok[0]) ||
                                (mode_e == MD_ACT_B && ok[1]));

    tw_history #(
        .TW_W(TW_W), .AVG_SHIFT(AVG_SHIFT), .CLAMP_LO(CLAMP_LO), .CLAMP_HI(CLAMP_HI)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .live_tw  (live_tw),
        .have_hist(have_hist),
        .hist_tw  (hist_tw)
    );

    ref_switch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_ok     (ok[0]),
        .b_ok     (ok[1]),
        .a_lvl    (lvl[0]),
        .b_lvl    (lvl[1]),
        .have_hist(have_hist),
        .man_hold (man_hold),
        .man_en   (man_en),
        .man_src  (man_src),
        .mode     (mode_e),
        .sel_b    (sel_b),
        .ref_out  (ref_out),
        .irq      (irq)
    );

    always_comb begin
        unique case (mode_e)
            MD_ACT_A, MD_ACT_B: tw_out = live_tw;
            MD_HOLD:            tw_out = hist_tw;
            default:            tw_out = FREE_TW;
        endcase
    end

    assign mode     = mode_e;
    assign ref_a_ok = ok[0];
    assign ref_b_ok = ok[1];

    assert_hold_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MD_HOLD) |-> (tw_out >= CLAMP_LO && tw_out <= CLAMP_HI));
    assert_sel_matches_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MD_ACT_B) |-> sel_b);
endmodule

// File: tb/sim_ref_switch_holdover.sv
`timescale 1ns/1ps
module sim_ref_switch_holdover;
    localparam logic [23:0] FREE_TW  = 24'h800000;
    localparam logic [23:0] CLAMP_LO = 24'h100000;
    localparam logic [23:0] CLAMP_HI = 24'hF00000;
    localparam int          SHIFT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_a = 1'b0, ref_b = 1'b0;
    logic [15:0] win_len = 16'd20;
    logic [3:0]  good_need = 4'd3;
    logic        man_hold = 1'b0, man_en = 1'b0, man_src = 1'b0, lock_ok = 1'b1;
    logic [23:0] live_tw = 24'h400000;
    logic        ref_out, sel_b, ref_a_ok, ref_b_ok, irq;
    logic [1:0]  mode;
    logic [23:0] tw_out;

    int n_chk = 0, n_bad = 0;
    int a_cnt = 0, b_cnt = 0, a_half = 4, b_half = 5;
    logic a_en = 1'b0, b_en = 1'b0;
    int hi_len = 0, pulse_bad = 0, pulse_seen = 0;
    int irq_bad = 0, irq_seen = 0;
    logic [1:0] prev_mode = 2'd0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ref_switch_holdover u0 (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
        .win_len(win_len), .good_need(good_need), .man_hold(man_hold),
        .man_en(man_en), .man_src(man_src), .lock_ok(lock_ok), .live_tw(live_tw),
        .ref_out(ref_out), .sel_b(sel_b), .mode(mode), .ref_a_ok(ref_a_ok),
        .ref_b_ok(ref_b_ok), .irq(irq), .tw_out(tw_out)
    );

    // reference generators: a stopped reference finishes its high phase, then stays low
    always @(negedge clk) begin
        if (a_cnt + 1 >= a_half) begin a_cnt <= 0; ref_a <= a_en ? ~ref_a : 1'b0; end
        else a_cnt <= a_cnt + 1;
        if (b_cnt + 1 >= b_half) begin b_cnt <= 0; ref_b <= b_en ? ~ref_b : 1'b0; end
        else b_cnt <= b_cnt + 1;
    end

    // R10 pulse-length watch and R11 interrupt watch
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_len    = 0;
            prev_mode = 2'd0;
        end else begin
            if (ref_out) hi_len++;
            else if (hi_len != 0) begin
                pulse_seen++;
                if (hi_len != a_half && hi_len != b_half) pulse_bad++;
                hi_len = 0;
            end
            if ((mode != prev_mode) != irq) irq_bad++;
            if (irq) irq_seen++;
            prev_mode = mode;
        end
    end

    function automatic logic [23:0] avg_step(input logic [23:0] avg, input logic [23:0] live);
        if (live >= avg) return avg + ((live - avg) >> SHIFT);
        return avg - ((avg - live) >> SHIFT);
    endfunction

    function automatic logic [23:0] clampw(input logic [23:0] v);
        if (v > CLAMP_HI) return CLAMP_HI;
        if (v < CLAMP_LO) return CLAMP_LO;
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        a_en = 1'b0; b_en = 1'b0;
        man_hold = 1'b0; man_en = 1'b0; man_src = 1'b0;
        wait_cyc(12);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] l0, l1, model;
        int k;
        void'($urandom(32'h1F2E3D));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R12 reset state
        check(mode == 2'd0, "R12 mode", mode, 0);
        check(tw_out == FREE_TW, "R12 tw_out", tw_out, FREE_TW);
        check(!sel_b && !ref_out && !irq, "R12 sel/out/irq", {sel_b, ref_out, irq}, 0);
        check(!ref_a_ok && !ref_b_ok, "R12 ok flags", {ref_a_ok, ref_b_ok}, 0);

        // R1 validity after good edges
        a_en = 1'b1;
        wait_cyc(6);
        check(!ref_a_ok, "R1 not yet valid", ref_a_ok, 0);
        wait_cyc(60);
        check(ref_a_ok, "R1 valid after good edges", ref_a_ok, 1);
        check(mode == 2'd1 && !sel_b, "R2 auto picks A", {mode, sel_b}, 2);
        for (int i = 0; i < 3; i++) begin
            live_tw = 24'($urandom);
            wait_cyc(1);
            check(tw_out == live_tw, "R7 live word in ACT", tw_out, live_tw);
        end

        // R2 B recovering does not displace A; R3 switchover on A failure
        b_en = 1'b1;
        wait_cyc(60);
        check(ref_b_ok && mode == 2'd1, "R2 stays on A", {ref_b_ok, mode}, 3'b101);
        a_en = 1'b0;
        wait_cyc(60);
        check(!ref_a_ok, "R1 quiet A fails", ref_a_ok, 0);
        check(mode == 2'd2 && sel_b, "R3 switchover to B", {mode, sel_b}, 3'b101);
        a_en = 1'b1;
        wait_cyc(60);
        check(ref_a_ok && mode == 2'd2, "R2 non-revertive", {ref_a_ok, mode}, 3'b110);

        // R6 manual selection, random source changes
        man_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            man_src = 1'($urandom);
            wait_cyc(30);
            check(mode == (man_src ? 2'd2 : 2'd1) && sel_b == man_src, "R6 manual source",
                  {mode, sel_b}, {(man_src ? 2'd2 : 2'd1), man_src});
        end
        man_hold = 1'b1;
        wait_cyc(10);
        check(mode == 2'd3, "R6 forced holdover", mode, 3);
        man_hold = 1'b0; man_en = 1'b0;
        wait_cyc(30);
        check(mode == 2'd1, "R5 leave holdover, R2 A first", mode, 1);

        // R6 manual source invalid -> holdover, not the other reference
        man_en = 1'b1; man_src = 1'b1; b_en = 1'b0;
        wait_cyc(60);
        check(mode == 2'd3 && ref_a_ok, "R6 invalid manual source", {mode, ref_a_ok}, 3'b111);
        b_en = 1'b1;
        wait_cyc(60);
        check(mode == 2'd2, "R5 exit holdover on return", mode, 2);
        man_en = 1'b0;

        // R4 all references fail with history -> HOLD
        a_en = 1'b0; b_en = 1'b0;
        wait_cyc(60);
        check(mode == 2'd3, "R4 holdover with history", mode, 3);

        // R4/R7 no history -> FREE
        lock_ok = 1'b0;
        do_reset();
        a_en = 1'b1;
        wait_cyc(60);
        check(mode == 2'd1, "R2 lock to A unlocked", mode, 1);
        a_en = 1'b0;
        wait_cyc(60);
        check(mode == 2'd0 && tw_out == FREE_TW, "R4 free-run word", tw_out, FREE_TW);

        // R8/R9 history average and clamp
        for (int t = 0; t < 5; t++) begin
            lock_ok = 1'b0;
            do_reset();
            a_en = 1'b1;
            wait_cyc(60);
            if (t == 3)      begin l0 = 24'hFA0000; l1 = 24'hFF0000; end
            else if (t == 4) begin l0 = 24'h020000; l1 = 24'h001000; end
            else begin
                l0 = CLAMP_LO + 24'($urandom % 32'hD00000);
                l1 = CLAMP_LO + 24'($urandom % 32'hD00000);
            end
            k = 1 + int'($urandom % 12);
            lock_ok = 1'b1; live_tw = l0;
            wait_cyc(1);
            live_tw = l1;
            wait_cyc(k);
            lock_ok = 1'b0;
            model = l0;
            for (int j = 0; j < k; j++) model = avg_step(model, l1);
            live_tw = 24'($urandom);
            a_en = 1'b0;
            wait_cyc(60);
            check(mode == 2'd3, "R4 holdover entered", mode, 3);
            check(tw_out == clampw(model), (t >= 3) ? "R9 clamped history" : "R8 running average",
                  tw_out, clampw(model));
        end

        check(pulse_bad == 0 && pulse_seen > 20, "R10 full-length pulses", pulse_bad, 0);
        check(irq_bad == 0 && irq_seen > 5, "R11 irq per mode change", irq_bad, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule